// File: doc/BRIEF.md
# DMA Bus Master Controller

This block lets an internal transfer engine move a run of 16-bit or 32-bit words over a multiplexed address/data processor bus. The engine hands over a job (word count, start address, direction, width and two cycle qualifiers) through a valid/ready handshake. The block then takes the bus as a master. It pulls an active-low request line low, waits for the active-low grant from the system arbiter and runs one machine cycle per 16-bit half-word on the oscillator clock.

A machine cycle takes five clocks: address, turn-around, two data clocks and recovery. The slave can stretch the first data clock with its active-low ready input. A 32-bit word takes two back-to-back cycles, low half first, each with its own address. The block also drives an active-low direction control for an external bidirectional buffer and a substitute sync pulse. When the last cycle ends it pulses a completion flag and lets go of the request. It floats the bus once the arbiter drops the grant. If the grant goes away while the request is still held, the block aborts and raises an error. It does the same when no grant arrives within a timeout window.

The pads are modelled as two output-enable signals: one for the address/data lines and one for the strobes and qualifiers. The write data is sampled together with the job, and that one 32-bit value is sent for every word of the run.

Top module: `dma_bus_master`

## Requirements
- R1: A job is taken when req_valid and req_ready are both high at a clock edge and req_count is nonzero. From the next clock, bus_req_n is low. Before a grant, addr_stb stays low and ctl_oe stays low.
- R2: ctl_oe and ad_oe are never high while bus_gnt_n is high. Raising bus_gnt_n drops both of them in the same clock.
- R3: Without wait states every machine cycle takes exactly 5 clocks, numbered phase 0 to phase 4, and the next cycle starts immediately after.
  - In phase 0, addr_stb and sync_sub are high and ad_out carries the cycle address with ad_oe high.
  - data_stb_n is low in phases 2 and 3.
- R4: Each clock edge in phase 2 at which ready_n is high repeats phase 2 once. W such edges make a cycle 5+W clocks long.
- R5: The addresses advance with each half-word.
  - A 32-bit word uses two cycles, the first at address A carrying bits 15:0 and the second at A+1 carrying bits 31:16. The next word starts at A+2.
  - 16-bit words use consecutive addresses.
  - Addresses wrap modulo 2^16.
- R6: The data phase depends on direction.
  - Write (req_write=1): the selected half of wr_data is on ad_out with ad_oe high, and dir_n is high.
  - Read: ad_oe is low after phase 0, and dir_n is low.
  - rd_not_wr equals the inverse of req_write.
  - Read data is taken from ad_in at the end of phase 3.
  - word_strobe pulses during the final phase 4 of each word, with rd_data valid. A 32-bit word is returned as {high cycle, low cycle}. A 16-bit read is zero-extended.
- R7: The clock after the last cycle's phase 4, done pulses for one clock and bus_req_n returns high. The controls stay enabled until bus_gnt_n goes high, and float at that point. req_ready is high from the next clock.
- R8: If bus_gnt_n goes high while the block holds ownership and bus_req_n is still low, the bus floats at once. In the next clock xfer_err pulses, bus_req_n goes high, done stays low and the block is idle again.
- R9: If no grant arrives, bus_req_n stays low for exactly TMO_CLKS clocks, where TMO_CLKS = OSC_KHZ*TMO_US/1000. Then xfer_err pulses and bus_req_n returns high.
- R10: req_ready is low from acceptance until the block is idle again. A request presented in that time is ignored and does not change the bus sequence. It also starts no later transfer.
- R11: During reset and after it: bus_req_n=1, req_ready=1, ctl_oe=0, ad_oe=0, done=0 and xfer_err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Job offered |
| req_ready | output | 1 | Block idle, job can be taken |
| req_count | input | CNT_W | Number of words, zero is ignored |
| req_addr | input | 16 | Start half-word address |
| req_write | input | 1 | 1 = write to bus, 0 = read from bus |
| req_wide | input | 1 | 1 = 32-bit words, 0 = 16-bit words |
| req_mem | input | 1 | Memory (1) or I/O (0) qualifier |
| req_instr | input | 1 | Instruction (1) or operand (0) qualifier |
| wr_data | input | 32 | Write pattern, sampled with the job |
| rd_data | output | 32 | Last word read |
| word_strobe | output | 1 | One word finished |
| done | output | 1 | Run completed cleanly |
| xfer_err | output | 1 | Run aborted (grant lost or timeout) |
| bus_req_n | output | 1 | Active-low bus request to arbiter |
| bus_gnt_n | input | 1 | Active-low grant from arbiter |
| ad_out | output | 16 | Address/data output value |
| ad_in | input | 16 | Address/data input value |
| ad_oe | output | 1 | Enable for the address/data pads |
| ctl_oe | output | 1 | Enable for strobes and qualifiers |
| addr_stb | output | 1 | Address strobe, high in phase 0 |
| data_stb_n | output | 1 | Active-low data strobe |
| rd_not_wr | output | 1 | 1 = read cycle |
| mem_not_io | output | 1 | Memory/I-O qualifier |
| instr_not_op | output | 1 | Instruction/operand qualifier |
| dir_n | output | 1 | Active-low buffer direction, low = inbound |
| ready_n | input | 1 | Active-low slave ready |
| sync_sub | output | 1 | Substitute sync pulse per cycle |

## Verification
The hardest case to reach from the ports is a grant that is withdrawn in the middle of a run, while a machine cycle is in flight and the request is still low. It differs from the normal hand-back only in whether the request has already been released. The stimulus grants a three-word read, follows the address strobes until the second cycle is in its data phase, and then raises the grant line between clock edges. The bench checks that the pad enables drop within the same clock and that the error pulse, not the completion pulse, follows at the next edge.

A second hard case is a foreign job offered during an active run. Ready-driven wait states are counted per cycle, so the bench can check every cycle length against 5+W exactly.

// File: rtl/dmab_pkg.sv
package dmab_pkg;
    localparam int BUS_W = 16;
    localparam int WORD_W = 2 * BUS_W;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_RUN  = 2'd2,
        S_REL  = 2'd3
    } seq_st_e;

    typedef struct packed {
        logic write;
        logic wide;
        logic mem;
        logic instr;
    } xfer_attr_t;

    function automatic logic [BUS_W-1:0] pick_half(input logic [WORD_W-1:0] w, input logic hi);
        return hi ? w[WORD_W-1:BUS_W] : w[BUS_W-1:0];
    endfunction

    function automatic logic word_closes(input xfer_attr_t a, input logic hsel);
        return !a.wide || hsel;
    endfunction
endpackage

// File: rtl/dmab_grant_wd.sv
module dmab_grant_wd #(
    parameter int LIMIT = 320,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    output logic          expire,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !arm) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(LIMIT - 1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = arm && (cnt_q == CW'(LIMIT - 1));
    assign cnt    = cnt_q;

    // R9
    wd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (arm && expire) |=> (cnt_q == CW'(LIMIT - 1)) || !arm);
endmodule

// File: rtl/dmab_mcycle.sv
module dmab_mcycle
    import dmab_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic             ready_n,
    input  logic [BUS_W-1:0] addr_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic             write_i,
    output logic             active_o,
    output logic             end_o,
    output logic             cap_o,
    output logic             as_o,
    output logic             ds_n_o,
    output logic             sync_o,
    output logic             drive_o,
    output logic             dir_n_o,
    output logic [BUS_W-1:0] ad_o
);
    localparam logic [2:0] PH_ADDR = 3'd0;
    localparam logic [2:0] PH_TURN = 3'd1;
    localparam logic [2:0] PH_DAT0 = 3'd2;
    localparam logic [2:0] PH_DAT1 = 3'd3;
    localparam logic [2:0] PH_RCV  = 3'd4;

    logic             active_q;
    logic [2:0]       ph_q;
    logic [BUS_W-1:0] addr_q;
    logic [BUS_W-1:0] wdata_q;
    logic             write_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            ph_q     <= PH_ADDR;
            addr_q   <= '0;
            wdata_q  <= '0;
            write_q  <= 1'b0;
        end else if (abort) begin
            active_q <= 1'b0;
            ph_q     <= PH_ADDR;
        end else if (start) begin
            active_q <= 1'b1;
            ph_q     <= PH_ADDR;
            addr_q   <= addr_i;
            wdata_q  <= wdata_i;
            write_q  <= write_i;
        end else if (active_q) begin
            if (ph_q == PH_RCV) begin
                active_q <= 1'b0;
                ph_q     <= PH_ADDR;
            end else if (!(ph_q == PH_DAT0 && ready_n)) begin
                ph_q <= ph_q + 1'b1;
            end
        end
    end

    assign active_o = active_q;
    assign end_o    = active_q && (ph_q == PH_RCV);
    assign cap_o    = active_q && (ph_q == PH_DAT1) && !write_q;
    assign as_o     = active_q && (ph_q == PH_ADDR);
    assign sync_o   = active_q && (ph_q == PH_ADDR || ph_q == PH_TURN);
    assign ds_n_o   = !(active_q && (ph_q == PH_DAT0 || ph_q == PH_DAT1));
    assign drive_o  = active_q && ((ph_q == PH_ADDR) || write_q);
    assign dir_n_o  = !(active_q && !write_q && (ph_q != PH_ADDR));
    assign ad_o     = (ph_q == PH_ADDR) ? addr_q : wdata_q;

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({as_o, !ds_n_o}));

    // R4
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && ph_q == PH_DAT0 && ready_n && !abort && !start) |=> (active_q && ph_q == PH_DAT0));

    // R3
    cycle_close_chk: assert property (@(posedge clk) disable iff (rst)
        (end_o && !start && !abort) |=> !active_q);
endmodule

// File: rtl/dma_bus_master.sv
module dma_bus_master
    import dmab_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int OSC_KHZ = 10000,
    parameter int TMO_US  = 32,
    localparam int TMO_CLKS = OSC_KHZ * TMO_US / 1000,
    localparam int WD_W     = $clog2(TMO_CLKS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [BUS_W-1:0]  req_addr,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic              req_mem,
    input  logic              req_instr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              word_strobe,
    output logic              done,
    output logic              xfer_err,
    output logic              bus_req_n,
    input  logic              bus_gnt_n,
    output logic [BUS_W-1:0]  ad_out,
    input  logic [BUS_W-1:0]  ad_in,
    output logic              ad_oe,
    output logic              ctl_oe,
    output logic              addr_stb,
    output logic              data_stb_n,
    output logic              rd_not_wr,
    output logic              mem_not_io,
    output logic              instr_not_op,
    output logic              dir_n,
    input  logic              ready_n,
    output logic              sync_sub
);
    seq_st_e           state_q;
    xfer_attr_t        attr_q;
    logic [BUS_W-1:0]  cur_addr_q;
    logic [CNT_W-1:0]  left_q;
    logic [WORD_W-1:0] wdata_q;
    logic [WORD_W-1:0] rdata_q;
    logic              hs_iss_q;
    logic              hs_end_q;
    logic              done_q;
    logic              err_q;

    logic              accept;
    logic              cyc_start;
    logic              cyc_abort;
    logic              finish;
    logic              tmo_hit;
    logic              cyc_active;
    logic              cyc_end;
    logic              cyc_cap;
    logic              cyc_as;
    logic              cyc_ds_n;
    logic              cyc_sync;
    logic              cyc_drive;
    logic              cyc_dir_n;
    logic [BUS_W-1:0]  cyc_ad;
    logic              wd_expire;
    logic [WD_W-1:0]   wd_cnt;
    logic              owns_bus;

    assign req_ready = (state_q == S_IDLE);
    assign accept    = req_valid && req_ready && (req_count != '0);
    assign cyc_abort = (state_q == S_RUN) && bus_gnt_n;
    assign cyc_start = (state_q == S_RUN) && !bus_gnt_n && (!cyc_active || cyc_end) && (left_q != '0);
    assign finish    = (state_q == S_RUN) && !bus_gnt_n && cyc_end && (left_q == '0);
    assign tmo_hit   = (state_q == S_REQ) && bus_gnt_n && wd_expire;
    assign owns_bus  = (state_q == S_RUN) || (state_q == S_REL);

    dmab_grant_wd #(.LIMIT(TMO_CLKS)) u_wd (
        .clk    (clk),
        .rst    (rst),
        .arm    (state_q == S_REQ),
        .expire (wd_expire),
        .cnt    (wd_cnt)
    );

    dmab_mcycle u_cyc (
        .clk      (clk),
        .rst      (rst),
        .start    (cyc_start),
        .abort    (cyc_abort),
        .ready_n  (ready_n),
        .addr_i   (cur_addr_q),
        .wdata_i  (pick_half(wdata_q, hs_iss_q)),
        .write_i  (attr_q.write),
        .active_o (cyc_active),
        .end_o    (cyc_end),
        .cap_o    (cyc_cap),
        .as_o     (cyc_as),
        .ds_n_o   (cyc_ds_n),
        .sync_o   (cyc_sync),
        .drive_o  (cyc_drive),
        .dir_n_o  (cyc_dir_n),
        .ad_o     (cyc_ad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= S_IDLE;
            attr_q     <= '0;
            cur_addr_q <= '0;
            left_q     <= '0;
            wdata_q    <= '0;
            rdata_q    <= '0;
            hs_iss_q   <= 1'b0;
            hs_end_q   <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            done_q <= finish;
            err_q  <= cyc_abort || tmo_hit;
            unique case (state_q)
                S_IDLE: if (accept) begin
                    state_q      <= S_REQ;
                    attr_q.write <= req_write;
                    attr_q.wide  <= req_wide;
                    attr_q.mem   <= req_mem;
                    attr_q.instr <= req_instr;
                    cur_addr_q   <= req_addr;
                    left_q       <= req_count;
                    wdata_q      <= wr_data;
                    hs_iss_q     <= 1'b0;
                    hs_end_q     <= 1'b0;
                end
                S_REQ: begin
                    if (!bus_gnt_n)   state_q <= S_RUN;
                    else if (tmo_hit) state_q <= S_IDLE;
                end
                S_RUN: begin
                    if (cyc_abort)   state_q <= S_IDLE;
                    else if (finish) state_q <= S_REL;
                end
                S_REL: if (bus_gnt_n) state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
            if (cyc_start) begin
                cur_addr_q <= cur_addr_q + 1'b1;
                hs_iss_q   <= attr_q.wide && !hs_iss_q;
                if (word_closes(attr_q, hs_iss_q)) left_q <= left_q - 1'b1;
            end
            if (cyc_end && attr_q.wide) hs_end_q <= !hs_end_q;
            if (cyc_cap) begin
                if (!attr_q.wide)  rdata_q <= {{BUS_W{1'b0}}, ad_in};
                else if (hs_end_q) rdata_q[WORD_W-1:BUS_W] <= ad_in;
                else               rdata_q[BUS_W-1:0] <= ad_in;
            end
        end
    end

    assign bus_req_n    = !((state_q == S_REQ) || (state_q == S_RUN));
    assign ctl_oe       = owns_bus && !bus_gnt_n;
    assign ad_oe        = ctl_oe && cyc_drive;
    assign ad_out       = cyc_ad;
    assign addr_stb     = cyc_as;
    assign data_stb_n   = cyc_ds_n;
    assign sync_sub     = cyc_sync;
    assign dir_n        = cyc_dir_n;
    assign rd_not_wr    = !attr_q.write;
    assign mem_not_io   = attr_q.mem;
    assign instr_not_op = attr_q.instr;
    assign rd_data      = rdata_q;
    assign word_strobe  = (state_q == S_RUN) && !bus_gnt_n && cyc_end && word_closes(attr_q, hs_end_q);
    assign done         = done_q;
    assign xfer_err     = err_q;

    // R1
    req_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !bus_req_n);

    // R8
    grant_loss_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RUN && bus_gnt_n) |=> (err_q && bus_req_n && !done_q));

    // R7
    done_release_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (bus_req_n && state_q == S_REL));

    // R9
    wd_window_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_REQ) |-> (wd_cnt < WD_W'(TMO_CLKS)));

    // R2
    strobe_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_as || !cyc_ds_n) |-> (state_q == S_RUN || state_q == S_REL));
endmodule

// File: tb/sim_dma_bus_master.sv
module sim_dma_bus_master;
    localparam int TMO = 32;

    typedef struct packed {
        logic [7:0]  cnt;
        logic [15:0] addr;
        logic        wr;
        logic        wide;
        logic [3:0]  waits;
        logic [3:0]  gdly;
        logic [31:0] wdata;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{8'd1, 16'h0100, 1'b1, 1'b0, 4'd0, 4'd2, 32'h0000BEEF},
        '{8'd3, 16'h0200, 1'b0, 1'b0, 4'd0, 4'd0, 32'h00000000},
        '{8'd2, 16'h0300, 1'b1, 1'b1, 4'd1, 4'd3, 32'h12345678},
        '{8'd2, 16'hFFFF, 1'b0, 1'b1, 4'd0, 4'd1, 32'h00000000},
        '{8'd1, 16'h0400, 1'b0, 1'b0, 4'd5, 4'd0, 32'h00000000},
        '{8'd2, 16'h0500, 1'b1, 1'b0, 4'd2, 4'd4, 32'hCAFE0042}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_count = '0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic        req_mem = 1'b1;
    logic        req_instr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        word_strobe, done, xfer_err, bus_req_n;
    logic        bus_gnt_n = 1'b1;
    logic [15:0] ad_out;
    logic [15:0] ad_in = '0;
    logic        ad_oe, ctl_oe, addr_stb, data_stb_n, rd_not_wr, mem_not_io, instr_not_op, dir_n;
    logic        ready_n = 1'b0;
    logic        sync_sub;

    int n_total = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dma_bus_master #(.CNT_W(8), .OSC_KHZ(1000), .TMO_US(32)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_count(req_count), .req_addr(req_addr), .req_write(req_write),
        .req_wide(req_wide), .req_mem(req_mem), .req_instr(req_instr),
        .wr_data(wr_data), .rd_data(rd_data), .word_strobe(word_strobe),
        .done(done), .xfer_err(xfer_err), .bus_req_n(bus_req_n), .bus_gnt_n(bus_gnt_n),
        .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .ctl_oe(ctl_oe),
        .addr_stb(addr_stb), .data_stb_n(data_stb_n), .rd_not_wr(rd_not_wr),
        .mem_not_io(mem_not_io), .instr_not_op(instr_not_op), .dir_n(dir_n),
        .ready_n(ready_n), .sync_sub(sync_sub)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] slave_val(input logic [15:0] a);
        return a ^ 16'h5A3C;
    endfunction

    task automatic run_xfer(input vec_t v, input bit inject);
        int t = 0;
        int c = -1;
        int dsc = 0;
        int wcnt = 0;
        int guard = 0;
        int nc;
        int w;
        bit started = 0;
        bit fin = 0;
        logic [15:0] ea;
        logic [31:0] ex;
        nc = v.wide ? 2 * int'(v.cnt) : int'(v.cnt);
        req_count = v.cnt; req_addr = v.addr; req_write = v.wr; req_wide = v.wide;
        wr_data = v.wdata; req_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        check(bus_req_n == 1'b0, "R1", {31'd0, bus_req_n}, 32'd0);
        check(req_ready == 1'b0, "R10", {31'd0, req_ready}, 32'd0);
        for (int i = 0; i < int'(v.gdly); i++) begin
            check(ctl_oe == 1'b0 && ad_oe == 1'b0 && addr_stb == 1'b0, "R2", {31'd0, ctl_oe}, 32'd0);
            @(negedge clk);
        end
        bus_gnt_n = 1'b0;
        while (!fin && guard < 4000) begin
            @(negedge clk);
            guard++;
            if (started) t++;
            if (addr_stb) begin
                c++;
                if (!started) begin started = 1; t = 0; end
                ea = v.addr + 16'(c);
                check(ad_out == ea && ad_oe == 1'b1, "R5", {16'd0, ad_out}, {16'd0, ea});
                check(sync_sub == 1'b1, "R3", {31'd0, sync_sub}, 32'd1);
                ad_in = slave_val(ea);
                dsc = 0;
                wcnt = int'(v.waits);
                if (inject && c == 0) begin
                    req_valid = 1'b1; req_count = 8'd5; req_addr = 16'h7777; req_write = ~v.wr;
                end
            end
            if (!data_stb_n) begin
                if (dsc == 0) begin
                    if (v.wr) begin
                        ex = {16'd0, (v.wide && c[0]) ? v.wdata[31:16] : v.wdata[15:0]};
                        check(ad_oe == 1'b1 && ad_out == ex[15:0] && dir_n == 1'b1, "R6", {16'd0, ad_out}, ex);
                    end else begin
                        check(ad_oe == 1'b0 && dir_n == 1'b0, "R6", {30'd0, ad_oe, dir_n}, 32'd0);
                    end
                    check(rd_not_wr == ~v.wr, "R6", {31'd0, rd_not_wr}, {31'd0, ~v.wr});
                    if (inject) check(req_ready == 1'b0, "R10", {31'd0, req_ready}, 32'd0);
                end
                dsc++;
            end
            if (word_strobe && !v.wr) begin
                w = v.wide ? c / 2 : c;
                if (v.wide) ex = {slave_val(v.addr + 16'(2 * w + 1)), slave_val(v.addr + 16'(2 * w))};
                else        ex = {16'd0, slave_val(v.addr + 16'(w))};
                check(rd_data == ex, "R6", rd_data, ex);
            end
            if (done) begin
                fin = 1;
                if (v.waits != 0) check(t == nc * (5 + int'(v.waits)), "R4", t, nc * (5 + int'(v.waits)));
                else              check(t == nc * 5, "R3", t, nc * 5);
                check(c + 1 == nc, "R5", c + 1, nc);
                check(bus_req_n == 1'b1 && ctl_oe == 1'b1, "R7", {30'd0, bus_req_n, ctl_oe}, 32'd3);
            end
            if (xfer_err) begin
                fin = 1;
                check(1'b0, "R8", 32'd1, 32'd0);
            end
            if (!data_stb_n && wcnt > 0) begin ready_n = 1'b1; wcnt--; end
            else ready_n = 1'b0;
            if (inject && dsc >= 2) req_valid = 1'b0;
        end
        if (!fin) check(1'b0, "R7", 32'd0, 32'd1);
        req_valid = 1'b0;
        ready_n = 1'b0;
        bus_gnt_n = 1'b1;
        #1;
        check(ctl_oe == 1'b0 && ad_oe == 1'b0, "R7", {30'd0, ctl_oe, ad_oe}, 32'd0);
        @(negedge clk);
        check(req_ready == 1'b1 && bus_req_n == 1'b1, "R7", {30'd0, req_ready, bus_req_n}, 32'd3);
        if (inject) begin
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                check(bus_req_n == 1'b1, "R10", {31'd0, bus_req_n}, 32'd1);
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        n_total++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(bus_req_n == 1'b1 && req_ready == 1'b1, "R11", {30'd0, bus_req_n, req_ready}, 32'd3);
        check(ctl_oe == 1'b0 && ad_oe == 1'b0 && done == 1'b0 && xfer_err == 1'b0, "R11",
              {28'd0, ctl_oe, ad_oe, done, xfer_err}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(bus_req_n == 1'b1 && req_ready == 1'b1, "R11", {30'd0, bus_req_n, req_ready}, 32'd3);

        foreach (TBL[k]) run_xfer(TBL[k], 1'b0);

        // R10 foreign job during a run
        run_xfer('{8'd2, 16'h0600, 1'b1, 1'b1, 4'd0, 4'd1, 32'hA1B2C3D4}, 1'b1);

        // R8 grant withdrawn mid-run
        req_count = 8'd3; req_addr = 16'h0800; req_write = 1'b0; req_wide = 1'b0; req_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        bus_gnt_n = 1'b0;
        n = 0;
        while (n < 2) begin
            @(negedge clk);
            if (addr_stb) n++;
        end
        @(negedge clk); @(negedge clk);
        bus_gnt_n = 1'b1;
        #1;
        check(ctl_oe == 1'b0 && ad_oe == 1'b0, "R2", {30'd0, ctl_oe, ad_oe}, 32'd0);
        @(negedge clk);
        check(xfer_err == 1'b1 && bus_req_n == 1'b1 && done == 1'b0, "R8",
              {29'd0, xfer_err, bus_req_n, done}, 32'd6);
        @(negedge clk);
        check(req_ready == 1'b1 && xfer_err == 1'b0, "R8", {30'd0, req_ready, xfer_err}, 32'd2);

        // R9 grant never arrives
        req_count = 8'd1; req_addr = 16'h0900; req_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (bus_req_n == 1'b0 && n < 100) begin
            check(xfer_err == 1'b0, "R9", {31'd0, xfer_err}, 32'd0);
            n++;
            @(negedge clk);
        end
        check(n == TMO, "R9", n, TMO);
        check(xfer_err == 1'b1, "R9", {31'd0, xfer_err}, 32'd1);

        // R1 zero count is not taken
        req_count = 8'd0; req_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        check(bus_req_n == 1'b1 && req_ready == 1'b1, "R1", {30'd0, bus_req_n, req_ready}, 32'd3);

        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule